// File: doc/BRIEF.md
# Segmented Program Counter with Displacement Rollover

This unit holds the fetch address of a small processor as two registers: an 8-bit code segment and an 8-bit instruction pointer. A relative jump adds a signed two's-complement displacement to the pointer, which wraps modulo 256. The wrap is passed on to the segment. Wrapping past the top raises the segment by one, and wrapping below zero lowers it by one. With segment carrying enabled, the pair therefore behaves as one 16-bit address that moves by a sign-extended offset. A carry-enable input can freeze the segment, and the pointer still wraps on its own.

Besides jumps, the unit takes a synchronous reset, a direct load of both registers and a plain sequential step of +1. The step carries into the segment in the same way as a +1 jump. The commands are prioritised: reset, then load, then jump, then step. Both registers change on the same rising clock edge. A combinational copy of the next address is also driven out, so a consumer can see the coming value one cycle early.

Top module: `segpc_unit`

## Requirements
- R1: With `rst` high at a rising edge, both registers become 0x00, whatever the other command inputs are.
- R2: With `loadEn` high and `rst` low, the next edge loads `loadSeg` and `loadPtr`, even if `jumpEn` or `stepEn` is also high.
- R3: A jump sets the pointer to (pointer + displacement) mod 256, where `jumpDisp` is read as 8-bit two's complement.
- R4: With carrying enabled, a non-negative displacement whose unsigned sum with the pointer exceeds 255 raises the segment by one (for example, 0x00:0xFE + 4 gives 0x01:0x02, and 0xFE + 20 gives pointer 18).
- R5: With carrying enabled, a negative displacement whose magnitude is larger than the pointer lowers the segment by one (0x05:0x00 − 20 gives 0x04:0xEC).
- R6: A jump that stays inside 0x00..0xFF leaves the segment unchanged, including a negative jump that lands exactly on 0x00.
- R7: With `carryEn` low, jumps and steps never change the segment, and the pointer still wraps modulo 256.
- R8: The segment wraps modulo 256: 0xFF raised becomes 0x00, and 0x00 lowered becomes 0xFF.
- R9: With `stepEn` the only command, the pointer advances by one, and a step from 0xFF carries into the segment when carrying is enabled.
- R10: When `jumpEn` and `stepEn` are both high (no reset, no load), only the jump is applied.
- R11: With no command asserted, both registers hold their values.
- R12: `nextSeg`/`nextPtr` equal the values the registers take at the following edge. With carrying enabled, a jump gives {segment, pointer} + sign-extended displacement, computed modulo 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, highest priority |
| loadEn | input | 1 | Load both registers from the load inputs |
| loadSeg | input | 8 | Segment value for a load |
| loadPtr | input | 8 | Pointer value for a load |
| jumpEn | input | 1 | Apply a relative jump |
| jumpDisp | input | 8 | Signed two's-complement displacement |
| stepEn | input | 1 | Advance the pointer by one |
| carryEn | input | 1 | Let pointer wraps change the segment |
| segOut | output | 8 | Current code segment |
| ptrOut | output | 8 | Current instruction pointer |
| nextSeg | output | 8 | Segment value taken at the next edge |
| nextPtr | output | 8 | Pointer value taken at the next edge |

## Verification
A wrong carry or borrow decision shows up on `nextSeg` in the same cycle the jump is presented, and on `segOut` one edge later. It is off by exactly one and appears only when the pointer crosses its range boundary. The bench therefore aims at the boundaries 0xFE/0xFF/0x00, the exact landing on zero, and segment values 0x00 and 0xFF. A corrupted pointer or a priority error is visible on `ptrOut` right after the offending edge. It also persists in every later address, so the long sweep against a 16-bit signed-add model keeps exposing it.

// File: rtl/segpc_pkg.sv
package segpc_pkg;

  // Strobes from the command decoder to the address datapath.
  typedef struct packed {
    logic clear;   // synchronous clear of both registers
    logic load;    // direct load of segment and pointer
    logic jump;    // relative displacement
    logic step;    // sequential +1
    logic segEn;   // pointer wrap may change the segment
  } segpcStrobes_t;

endpackage

// File: rtl/segpc_ctrl.sv
module segpc_ctrl
  import segpc_pkg::*;
(
  input  logic          rst,
  input  logic          loadEn,
  input  logic          jumpEn,
  input  logic          stepEn,
  input  logic          carryEn,
  output segpcStrobes_t strobes
);

  // Fixed priority: clear > load > jump > step.
  always_comb begin
    strobes       = '0;
    strobes.segEn = carryEn;
    if (rst) begin
      strobes.clear = 1'b1;
    end else if (loadEn) begin
      strobes.load = 1'b1;
    end else if (jumpEn) begin
      strobes.jump = 1'b1;
    end else if (stepEn) begin
      strobes.step = 1'b1;
    end
  end

endmodule

// File: rtl/segpc_ptradd.sv
module segpc_ptradd #(
  parameter int PTR_W = 8
) (
  input  logic [PTR_W-1:0] ptrIn,
  input  logic [PTR_W-1:0] offset,
  output logic [PTR_W-1:0] ptrSum,
  output logic             wrapUp,
  output logic             wrapDown
);

  localparam int SIGN_BIT = PTR_W - 1;

  logic [PTR_W:0] wideSum;
  logic           offsetNeg;

  // Unsigned sum with one extra bit; its top bit is the carry out.
  assign wideSum   = {1'b0, ptrIn} + {1'b0, offset};
  assign offsetNeg = offset[SIGN_BIT];
  assign ptrSum    = wideSum[PTR_W-1:0];

  // Non-negative offset with carry: crossed the top.
  // Negative offset without carry: magnitude exceeded the pointer.
  assign wrapUp    = !offsetNeg &&  wideSum[PTR_W];
  assign wrapDown  =  offsetNeg && !wideSum[PTR_W];

endmodule

// File: rtl/segpc_datapath.sv
module segpc_datapath
  import segpc_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter int SEG_W = 8
) (
  input  logic             clk,
  input  segpcStrobes_t    strobes,
  input  logic [SEG_W-1:0] loadSeg,
  input  logic [PTR_W-1:0] loadPtr,
  input  logic [PTR_W-1:0] jumpDisp,
  output logic [SEG_W-1:0] segQ,
  output logic [PTR_W-1:0] ptrQ,
  output logic [SEG_W-1:0] segNext,
  output logic [PTR_W-1:0] ptrNext
);

  localparam logic [PTR_W-1:0] STEP_ONE = PTR_W'(1);
  localparam logic [SEG_W-1:0] SEG_ONE  = SEG_W'(1);
  localparam int               ADDR_W   = SEG_W + PTR_W;

  logic [PTR_W-1:0] offset;
  logic [PTR_W-1:0] ptrSum;
  logic             wrapUp;
  logic             wrapDown;
  logic [SEG_W-1:0] segAdj;

  // A step is a +1 jump through the same adder.
  assign offset = strobes.jump ? jumpDisp : STEP_ONE;

  segpc_ptradd #(.PTR_W(PTR_W)) uAdd (
    .ptrIn   (ptrQ),
    .offset  (offset),
    .ptrSum  (ptrSum),
    .wrapUp  (wrapUp),
    .wrapDown(wrapDown)
  );

  always_comb begin
    segAdj = segQ;
    if (strobes.segEn && wrapUp) begin
      segAdj = segQ + SEG_ONE;
    end else if (strobes.segEn && wrapDown) begin
      segAdj = segQ - SEG_ONE;
    end
  end

  always_comb begin
    segNext = segQ;
    ptrNext = ptrQ;
    if (strobes.clear) begin
      segNext = '0;
      ptrNext = '0;
    end else if (strobes.load) begin
      segNext = loadSeg;
      ptrNext = loadPtr;
    end else if (strobes.jump || strobes.step) begin
      segNext = segAdj;
      ptrNext = ptrSum;
    end
  end

  always_ff @(posedge clk) begin
    segQ <= segNext;
    ptrQ <= ptrNext;
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk)
    strobes.clear |=> (segQ == '0) && (ptrQ == '0)); // R1

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.load |=> (segQ == $past(loadSeg)) && (ptrQ == $past(loadPtr))); // R2

  AST_PTR_MODULO: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.jump |=> ptrQ == PTR_W'($past(ptrQ) + $past(jumpDisp))); // R3

  AST_JUMP_16BIT: assert property (@(posedge clk) disable iff (strobes.clear)
    (strobes.jump && strobes.segEn) |=>
      {segQ, ptrQ} == ADDR_W'($past({segQ, ptrQ}) +
        {{SEG_W{$past(jumpDisp[PTR_W-1])}}, $past(jumpDisp)})); // R4

  AST_SEG_FROZEN: assert property (@(posedge clk) disable iff (strobes.clear)
    (!strobes.load && !strobes.segEn) |=> segQ == $past(segQ)); // R7

  AST_SEG_UNIT_MOVE: assert property (@(posedge clk) disable iff (strobes.clear)
    !strobes.load |=> (segQ == $past(segQ)) ||
                      (segQ == SEG_W'($past(segQ) + SEG_ONE)) ||
                      (segQ == SEG_W'($past(segQ) - SEG_ONE))); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (strobes.clear)
    (!strobes.load && !strobes.jump && !strobes.step) |=>
      $stable(segQ) && $stable(ptrQ)); // R11

endmodule

// File: rtl/segpc_unit.sv
module segpc_unit
  import segpc_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter int SEG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loadEn,
  input  logic [SEG_W-1:0] loadSeg,
  input  logic [PTR_W-1:0] loadPtr,
  input  logic             jumpEn,
  input  logic [PTR_W-1:0] jumpDisp,
  input  logic             stepEn,
  input  logic             carryEn,
  output logic [SEG_W-1:0] segOut,
  output logic [PTR_W-1:0] ptrOut,
  output logic [SEG_W-1:0] nextSeg,
  output logic [PTR_W-1:0] nextPtr
);

  segpcStrobes_t strobes;

  segpc_ctrl uCtrl (
    .rst    (rst),
    .loadEn (loadEn),
    .jumpEn (jumpEn),
    .stepEn (stepEn),
    .carryEn(carryEn),
    .strobes(strobes)
  );

  segpc_datapath #(.PTR_W(PTR_W), .SEG_W(SEG_W)) uPath (
    .clk     (clk),
    .strobes (strobes),
    .loadSeg (loadSeg),
    .loadPtr (loadPtr),
    .jumpDisp(jumpDisp),
    .segQ    (segOut),
    .ptrQ    (ptrOut),
    .segNext (nextSeg),
    .ptrNext (nextPtr)
  );

endmodule

// File: tb/tb_segpc_unit.sv
module tb_segpc_unit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       loadEn = 1'b0, jumpEn = 1'b0, stepEn = 1'b0, carryEn = 1'b1;
  logic [7:0] loadSeg = '0, loadPtr = '0, jumpDisp = '0;
  logic [7:0] segOut, ptrOut, nextSeg, nextPtr;

  int checks = 0;
  int fails  = 0;

  logic [7:0] mSeg = '0, mPtr = '0;

  always #2.5 clk = ~clk;

  segpc_unit dut (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadSeg(loadSeg), .loadPtr(loadPtr),
    .jumpEn(jumpEn), .jumpDisp(jumpDisp), .stepEn(stepEn), .carryEn(carryEn),
    .segOut(segOut), .ptrOut(ptrOut), .nextSeg(nextSeg), .nextPtr(nextPtr)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference: 16-bit add of sign-extended offset, or pointer-only wrap.
  task automatic model(input logic [7:0] d, input logic ce);
    logic [15:0] s;
    if (ce) begin
      s = {mSeg, mPtr} + {{8{d[7]}}, d};
      mSeg = s[15:8];
      mPtr = s[7:0];
    end else begin
      mPtr = mPtr + d;
    end
  endtask

  // Present a command at the falling edge, check next-address, then registers.
  task automatic apply(input string req, input logic r, input logic ld, input logic jp,
                       input logic st, input logic ce, input logic [7:0] ls,
                       input logic [7:0] lp, input logic [7:0] d,
                       input logic [7:0] eSeg, input logic [7:0] ePtr);
    @(negedge clk);
    rst = r; loadEn = ld; jumpEn = jp; stepEn = st; carryEn = ce;
    loadSeg = ls; loadPtr = lp; jumpDisp = d;
    #1;
    check({req, " next"}, {nextSeg, nextPtr}, {eSeg, ePtr});
    @(posedge clk);
    #1;
    check(req, {segOut, ptrOut}, {eSeg, ePtr});
    rst = 1'b0; loadEn = 1'b0; jumpEn = 1'b0; stepEn = 1'b0;
    mSeg = eSeg; mPtr = ePtr;
  endtask

  task automatic doLoad(input logic [7:0] s, input logic [7:0] p);
    apply("R2 load", 0, 1, 0, 0, 1, s, p, 8'h00, s, p);
  endtask

  task automatic testReset();
    apply("R1 reset", 1, 0, 0, 0, 1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    doLoad(8'h12, 8'h34);
    apply("R1 reset over load/jump", 1, 1, 1, 1, 1, 8'h55, 8'h66, 8'h07, 8'h00, 8'h00);
  endtask

  task automatic testCarryUp();
    doLoad(8'h00, 8'hFE);
    apply("R4 +4 from FE", 0, 0, 1, 0, 1, 0, 0, 8'h04, 8'h01, 8'h02);
    doLoad(8'h00, 8'hFE);
    apply("R4 +20 from 254", 0, 0, 1, 0, 1, 0, 0, 8'd20, 8'h01, 8'd18);
    apply("R3 +127 mod 256", 0, 0, 1, 0, 1, 0, 0, 8'h7F, 8'h01, 8'h91);
  endtask

  task automatic testBorrow();
    doLoad(8'h05, 8'h00);
    apply("R5 -20 from 0", 0, 0, 1, 0, 1, 0, 0, 8'hEC, 8'h04, 8'd236);
    doLoad(8'h05, 8'h10);
    apply("R6 +5 inside", 0, 0, 1, 0, 1, 0, 0, 8'h05, 8'h05, 8'h15);
    apply("R6 -3 inside", 0, 0, 1, 0, 1, 0, 0, 8'hFD, 8'h05, 8'h12);
    apply("R6 -18 lands on 0", 0, 0, 1, 0, 1, 0, 0, 8'hEE, 8'h05, 8'h00);
    apply("R5 -1 from 0", 0, 0, 1, 0, 1, 0, 0, 8'hFF, 8'h04, 8'hFF);
    apply("R3 -128", 0, 0, 1, 0, 1, 0, 0, 8'h80, 8'h04, 8'h7F);
  endtask

  task automatic testNoCarry();
    doLoad(8'h07, 8'hFE);
    apply("R7 +4 frozen seg", 0, 0, 1, 0, 0, 0, 0, 8'h04, 8'h07, 8'h02);
    apply("R7 -4 frozen seg", 0, 0, 1, 0, 0, 0, 0, 8'hFC, 8'h07, 8'hFE);
    doLoad(8'h07, 8'hFF);
    apply("R7 step frozen seg", 0, 0, 0, 1, 0, 0, 0, 8'h00, 8'h07, 8'h00);
  endtask

  task automatic testSegWrap();
    doLoad(8'hFF, 8'hF0);
    apply("R8 seg FF up", 0, 0, 1, 0, 1, 0, 0, 8'h20, 8'h00, 8'h10);
    apply("R8 seg 00 down", 0, 0, 1, 0, 1, 0, 0, 8'hE0, 8'hFF, 8'hF0);
  endtask

  task automatic testStep();
    doLoad(8'h03, 8'hFE);
    apply("R9 step", 0, 0, 0, 1, 1, 0, 0, 8'h55, 8'h03, 8'hFF);
    apply("R9 step carries", 0, 0, 0, 1, 1, 0, 0, 8'h55, 8'h04, 8'h00);
  endtask

  task automatic testPriority();
    doLoad(8'h20, 8'h40);
    apply("R2 load over jump/step", 0, 1, 1, 1, 1, 8'hA0, 8'hB0, 8'h33, 8'hA0, 8'hB0);
    apply("R10 jump over step", 0, 0, 1, 1, 1, 0, 0, 8'h10, 8'hA0, 8'hC0);
  endtask

  task automatic testIdle();
    doLoad(8'h9A, 8'hBC);
    apply("R11 idle", 0, 0, 0, 0, 1, 8'h11, 8'h22, 8'h7F, 8'h9A, 8'hBC);
    apply("R11 idle no carry", 0, 0, 0, 0, 0, 8'h11, 8'h22, 8'h80, 8'h9A, 8'hBC);
  endtask

  task automatic testSweep();
    logic [15:0] lfsr = 16'hACE1;
    doLoad(8'h80, 8'h00);
    for (int i = 0; i < 300; i++) begin
      logic ce;
      logic [7:0] d;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      d  = lfsr[7:0];
      ce = (lfsr[11:9] != 3'b000);
      model(d, ce);
      apply("R12 sweep", 0, 0, 1, 0, ce, 0, 0, d, mSeg, mPtr);
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset state", {segOut, ptrOut}, 16'h0000);
    rst = 1'b0;
    testReset();
    testCarryUp();
    testBorrow();
    testNoCarry();
    testSegWrap();
    testStep();
    testPriority();
    testIdle();
    testSweep();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule